// File: doc/BRIEF.md
# Multiplier-Free Inner-Product Accumulator

This block forms the sum of products y = a1·x1 + ... + aL·xL for up to eight two's-complement fractional variables without any multiplier. Each variable is a B-bit fraction of magnitude at most 1. Its top bit carries weight −1 and each lower bit carries half the weight of the bit above it. Outside the block, a table holds, for every pattern of one bit per variable, the sum of the coefficients whose variable has a 1 in that bit. The block announces which bit position (the "slice") it needs next. It then takes the matching table word, adds it into a double-width accumulator and halves the running sum by an arithmetic shift.

Slices are consumed from the least significant (slice B−1) toward the sign (slice 0). The sign slice is handled last, and its table word is subtracted rather than added, with no shift after it. The accumulator is cleared when a computation starts. The result is loaded once the sign slice has been handled and holds until the next computation completes. The number of table words a computation needs is always B, whatever the number of variables in the sum. The table source may hold back a word by keeping the valid input low.

Top module: `da_inner_product`

## Requirements
- R1: After reset, busy, done and result are all 0 and slice_idx is 0.
- R2: A start pulse while busy is low sets busy on the next clock edge, loads slice_idx with B−1 and clears the accumulator.
- R3: While busy, every clock edge with tbl_valid high consumes tbl_word as the table entry for slice slice_idx. Slice i stands for bit (B−1−i) of every variable, so slice 0 is the sign bit. After consuming a word with slice_idx ≠ 0, slice_idx decrements by one.
- R4: With the defaults W = B = 16, the final result read as signed 2W bits equals 2·Σ a_j·X_j. Here X_j is the variable's raw 16-bit pattern read as a signed integer and a_j an integer coefficient. This is the fraction product scaled by 2^W, and it is exact for all inputs, including X = −32768.
- R5: The word consumed for slice 0 is subtracted from the accumulator, not added. A computation whose variables set only their sign bits gives −F·2^W, where F is the table word for slice 0.
- R6: An edge with tbl_valid low while busy changes neither slice_idx nor the accumulator, and it does not count toward the B words.
- R7: done is high for exactly one cycle. It goes high on the edge that consumes the slice 0 word, the same edge on which busy falls and result is loaded. With tbl_valid held high this edge is B clock edges after the start edge.
- R8: A start pulse while busy is ignored. The running computation is neither restarted nor changed.
- R9: result changes only on the edge that consumes the slice 0 word. Otherwise it holds its value, whatever start, tbl_valid and tbl_word do.
- R10: The number of cycles per computation is the same for one summed term as for eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (taken only while idle) |
| tbl_valid | input | 1 | tbl_word holds the entry for the current slice |
| tbl_word | input | W | Signed table entry for slice slice_idx |
| slice_idx | output | $clog2(B) | Slice whose table entry is wanted |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when result is loaded |
| result | output | 2W | Signed inner product scaled by 2^W |

## Verification
The assertions assume that tbl_word always holds the entry for the slice currently shown on slice_idx. They also assume that the coefficients are small enough for every table entry to fit in W signed bits and for the final sum to fit in 2W bits. Their own checks rest on nothing beyond the handshake itself: the slice counter, the single-cycle done and the holding of the result. The bench recomputes each table word from slice_idx, sampled between edges, before driving it. It draws coefficients from −4095 to 4095, so eight of them can never overflow a 16-bit entry, even with every variable at its most negative value.

// File: rtl/da_ip_pkg.sv
package da_ip_pkg;
  typedef enum logic [1:0] {
    OP_IDLE      = 2'd0,
    OP_ADD_SHIFT = 2'd1,
    OP_SUB_FINAL = 2'd2
  } da_op_e;
endpackage

// File: rtl/da_slice_ctrl.sv
module da_slice_ctrl
  import da_ip_pkg::*;
#(
  parameter int B  = 16,
  parameter int IW = $clog2(B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tbl_valid,
  output logic          clr,
  output da_op_e        op,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(B - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    clr    = 1'b0;
    op     = OP_IDLE;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = LAST_IDX;
        clr    = 1'b1;
      end
    end else if (tbl_valid) begin
      if (idx_q == '0) begin
        op     = OP_SUB_FINAL;
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        op    = OP_ADD_SHIFT;
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign idx  = idx_q;
  assign busy = busy_q;
  assign done = done_q;

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy_q && idx_q == LAST_IDX));
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tbl_valid && idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tbl_valid) |=> (busy_q && $stable(idx_q)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && idx_q != '0) |=> busy_q);
endmodule

// File: rtl/da_acc_path.sv
module da_acc_path
  import da_ip_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  da_op_e        op,
  input  logic [W-1:0]  word,
  output logic [AW-1:0] result
);
  logic [AW-1:0] acc_q, acc_d;
  logic [AW-1:0] res_q, res_d;
  logic [AW:0]   sum_wide;
  logic [AW-1:0] diff;

  // guard bit keeps the add exact before the halving shift
  assign sum_wide = {acc_q[AW-1], acc_q} + {word[W-1], word, {W{1'b0}}};
  assign diff     = acc_q - {word, {W{1'b0}}};

  always_comb begin
    acc_d = acc_q;
    res_d = res_q;
    if (clr) begin
      acc_d = '0;
    end else begin
      case (op)
        OP_ADD_SHIFT: acc_d = sum_wide[AW:1];
        OP_SUB_FINAL: begin
          acc_d = diff;
          res_d = diff;
        end
        default: acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;

  assert_clear_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0));
  assert_stall_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE && !clr) |=> $stable(acc_q));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_SUB_FINAL) |=> $stable(res_q));
endmodule

// File: rtl/da_inner_product.sv
module da_inner_product
  import da_ip_pkg::*;
#(
  parameter int W  = 16,
  parameter int B  = 16,
  parameter int IW = $clog2(B)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tbl_valid,
  input  logic [W-1:0]    tbl_word,
  output logic [IW-1:0]   slice_idx,
  output logic            busy,
  output logic            done,
  output logic [2*W-1:0]  result
);
  logic   clr;
  da_op_e op;

  da_slice_ctrl #(.B(B), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tbl_valid (tbl_valid),
    .clr       (clr),
    .op        (op),
    .idx       (slice_idx),
    .busy      (busy),
    .done      (done)
  );

  da_acc_path #(.W(W), .AW(2 * W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .op     (op),
    .word   (tbl_word),
    .result (result)
  );
endmodule

// File: tb/da_inner_product_tb.sv
module da_inner_product_tb;
  localparam int W  = 16;
  localparam int B  = 16;
  localparam int IW = $clog2(B);

  logic            clk;
  logic            rst_n;
  logic            start;
  logic            tbl_valid;
  logic [W-1:0]    tbl_word;
  logic [IW-1:0]   slice_idx;
  logic            busy;
  logic            done;
  logic [2*W-1:0]  result;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  int          coef [8];
  logic [B-1:0] xv  [8];
  int          nterm;

  da_inner_product #(.W(W), .B(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_valid(tbl_valid),
    .tbl_word(tbl_word), .slice_idx(slice_idx), .busy(busy),
    .done(done), .result(result)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] table_word(input int i);
    int s = 0;
    for (int j = 0; j < nterm; j++)
      if (xv[j][B-1-i]) s += coef[j];
    return W'(s);
  endfunction

  function automatic longint model();
    longint s = 0;
    for (int j = 0; j < nterm; j++)
      s += longint'(coef[j]) * longint'($signed(xv[j]));
    return s <<< (W - B + 1);
  endfunction

  // runs one computation; gap>0 drops valid every gap-th cycle
  task automatic run_ip(input int gap, input bit poke, output longint res, output int cyc, output int used, output bit seq_ok);
    int exp_idx = B - 1;
    cyc = 0; used = 0; seq_ok = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    forever begin
      if (done) break;
      if (cyc > 2000) break;
      if (!busy || slice_idx != IW'(exp_idx)) seq_ok = 0;
      tbl_valid = (gap == 0) || ((cyc % gap) != gap - 1);
      tbl_word  = table_word(int'(slice_idx));
      start     = poke && (cyc == 3 || cyc == 4);
      if (tbl_valid) begin used++; exp_idx--; end
      @(negedge clk); cyc++;
    end
    start = 0; tbl_valid = 0;
    res = longint'($signed(result));
    check(!busy, "R7 busy low with done", longint'(busy), 0);
    @(negedge clk);
    check(!done, "R7 done single cycle", longint'(done), 0);
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0, "R1 busy/done after reset", longint'({busy, done}), 0);
    check(result == '0, "R1 result after reset", longint'(result), 0);
    check(slice_idx == '0, "R1 slice_idx after reset", longint'(slice_idx), 0);
  endtask

  task automatic t_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy == 1, "R2 busy after start", longint'(busy), 1);
    check(slice_idx == IW'(B - 1), "R2 first slice", longint'(slice_idx), B - 1);
    // finish this run so the block is idle again
    for (int k = 0; k < B; k++) begin
      tbl_valid = 1; tbl_word = '0;
      @(negedge clk);
    end
    tbl_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_half;
    longint r; int c, u; bit sq;
    nterm = 1; coef[0] = 1000; xv[0] = 16'h4000;
    run_ip(0, 0, r, c, u, sq);
    check(r == model(), "R4 single term 0.5*1000", r, model());
    check(sq, "R3 slice order", longint'(sq), 1);
    check(c == B, "R7 latency one term", c, B);
  endtask

  task automatic t_sign_only;
    longint r; int c, u; bit sq; longint f;
    nterm = 8;
    for (int j = 0; j < 8; j++) begin coef[j] = (j % 2 == 0) ? 4095 - j : -4000 + j; xv[j] = 16'h8000; end
    f = longint'($signed(table_word(0)));
    run_ip(0, 0, r, c, u, sq);
    check(r == -(f <<< W), "R5 sign slice subtracted", r, -(f <<< W));
    check(r == model(), "R4 most negative inputs", r, model());
  endtask

  task automatic t_random;
    longint r; int c, u; bit sq;
    for (int t = 0; t < 20; t++) begin
      nterm = 8;
      for (int j = 0; j < 8; j++) begin
        coef[j] = int'($urandom_range(0, 8190)) - 4095;
        xv[j]   = (t % 5 == 0 && j == t % 8) ? 16'h8000 : B'($urandom);
      end
      run_ip(0, 0, r, c, u, sq);
      check(r == model(), "R4 random eight terms", r, model());
      check(c == B, "R10 latency eight terms", c, B);
    end
  endtask

  task automatic t_stall;
    longint r; int c, u; bit sq;
    nterm = 8;
    for (int j = 0; j < 8; j++) begin coef[j] = 300 * j - 1000; xv[j] = B'($urandom); end
    run_ip(3, 0, r, c, u, sq);
    check(r == model(), "R6 result with stalls", r, model());
    check(u == B, "R6 words consumed", u, B);
    check(c > B, "R6 run stretched by stalls", c, B + 1);
    check(sq, "R6 slice held during stall", longint'(sq), 1);
  endtask

  task automatic t_busy_start;
    longint r; int c, u; bit sq;
    nterm = 4;
    for (int j = 0; j < 4; j++) begin coef[j] = 2047 - 999 * j; xv[j] = B'($urandom); end
    run_ip(0, 1, r, c, u, sq);
    check(r == model(), "R8 result with start while busy", r, model());
    check(c == B && sq, "R8 no restart", c, B);
  endtask

  task automatic t_hold;
    logic [2*W-1:0] keep = result;
    for (int k = 0; k < 6; k++) begin
      tbl_valid = k[0]; tbl_word = B'($urandom);
      @(negedge clk);
    end
    tbl_valid = 0;
    check(result == keep, "R9 result held while idle", longint'($signed(result)), longint'($signed(keep)));
  endtask

  initial begin
    rst_n = 0; start = 0; tbl_valid = 0; tbl_word = '0; nterm = 0;
    for (int j = 0; j < 8; j++) begin coef[j] = 0; xv[j] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_start();
    t_half();
    t_sign_only();
    t_random();
    t_stall();
    t_busy_start();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule